// File: doc/BRIEF.md
# Static Memory Read Timing Sequencer

This block runs read cycles on an external static memory bus that has several chip-select banks. A host presents a request with a bank number and an address while the sequencer is idle. The sequencer then drives the address and the bank's active-low select. It asserts the active-low read strobe for a programmed time, captures the data bus, and returns the word with a one-cycle done pulse. Each bank has its own static timing inputs: setup code, strobe code, hold code, data-float code and a standard-wait enable.

The block clock `clk` runs at twice the memory bus rate, so one `clk` period is half a bus cycle. Setup code `s` gives s+0.5 bus cycles of setup, and code 0 gives no setup. Strobe code `c` gives c+1.5 bus cycles. Hold code `h` gives h whole bus cycles. After a read, the bank's data-float time keeps counting down. A read to another bank lets that remaining time overlap its own setup. A read to the same bank waits for the time to expire.

State machine states: `ST_IDLE` (bus released, ready for a request), `ST_DRAIN` (select released, waiting for the same bank's data-float time), `ST_SETUP`, `ST_STROBE` and `ST_HOLD`.
Transitions:
- `ST_IDLE` to `ST_DRAIN`, taken when the accepted bank's float counter is nonzero.
- `ST_IDLE` or `ST_DRAIN` to `ST_SETUP`, taken when the setup to insert is nonzero.
- `ST_IDLE` or `ST_DRAIN` to `ST_STROBE`, taken when the setup to insert is zero.
- `ST_SETUP` to `ST_STROBE`, taken when the setup count expires.
- `ST_STROBE` to `ST_HOLD`, taken when the strobe expires and the hold is nonzero.
- `ST_STROBE` or `ST_HOLD` to `ST_IDLE`, taken when the access ends.
- A refused request leaves `ST_IDLE` unchanged.

Top module: `smc_read_seq`

## Requirements
- R1: After reset and whenever no access is active, all chip selects and the read strobe are high, and `req_ready_o` is 1.
- R2: With no float time pending, a bank with setup code s>0 holds its select low and the strobe high for 2s+1 `clk` cycles before the strobe falls. Code 0 gives no setup cycles.
- R3: The strobe stays low for 2c+3 `clk` cycles for strobe code c, or 2c+5 cycles when that bank's standard-wait bit is 1.
- R4: After the strobe rises, the select stays low for 2h `clk` cycles for hold code h. The strobe is low only while a select is low.
- R5: The data bus value present in the last strobe cycle appears on `rd_data_o`, and `rd_done_o` is 1 for exactly the first cycle after the select is released.
- R6: Only the select of the requested bank goes low, and bank b uses bit b of `mem_cs_n_o`. The address stays on `mem_addr_o` for the whole access.
- R7: Each access ends by loading twice the bank's float code into that bank's float counter, which falls by one every `clk` cycle. The new request may go to a bank other than the one last read. If the leftover count L of the last-read bank is at least 2s for the new setup code s, the access starts with the strobe and has no setup and no idle gap.
- R8: If that leftover L is below 2s, the access inserts 2s+1-L setup cycles.
- R9: A request to a bank whose own float counter is nonzero keeps all selects high until that counter reaches zero, then runs the full setup. The gap equals the counter value at acceptance.
- R10: A request with setup code nonzero, hold code zero and the standard-wait bit 0 is refused. `cfg_err_o` is 1 for one cycle, no select goes low, and the sequencer stays ready.
- R11: A request made while an access is active is ignored. The running access keeps its address and select, and no access follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup_i | input | NUM_BANKS*3 | Setup code per bank (bank b at bits 3b+2:3b) |
| cfg_pulse_i | input | NUM_BANKS*7 | Strobe code per bank |
| cfg_hold_i | input | NUM_BANKS*3 | Hold code per bank |
| cfg_float_i | input | NUM_BANKS*4 | Data-float code per bank, in bus cycles |
| cfg_wait_i | input | NUM_BANKS | Standard-wait enable per bank |
| req_i | input | 1 | Read request, sampled while idle |
| req_bank_i | input | $clog2(NUM_BANKS) | Bank of the request |
| req_addr_i | input | ADDR_W | Address of the request |
| req_ready_o | output | 1 | Sequencer idle and accepting |
| rd_data_o | output | DATA_W | Captured read data |
| rd_done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | One-cycle pulse for a refused illegal timing |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_cs_n_o | output | NUM_BANKS | Active-low chip selects |
| mem_rd_n_o | output | 1 | Active-low read strobe |
| mem_data_i | input | DATA_W | Memory data bus |

## Verification
The assertions assume that the timing inputs of a bank stay constant while that bank has an access in flight. They also assume the request bank is below `NUM_BANKS`. The bench meets both conditions by changing configuration only while the sequencer is idle and by using banks 0 to 3 only. The refusal property assumes a refused request always arrives while idle, which the ready flag guarantees. The bench issues back-to-back requests in the done cycle so that the float-absorption cases see a known leftover count.

// File: rtl/smc_rd_pkg.sv
package smc_rd_pkg;

    localparam int SETUP_CODE_W = 3;
    localparam int PULSE_CODE_W = 7;
    localparam int HOLD_CODE_W  = 3;
    localparam int FLOAT_CODE_W = 4;

    // widest phase: 2*(2^PULSE_CODE_W - 1) + 5 half-cycles
    localparam int PHASE_W = PULSE_CODE_W + 2;
    localparam int FLOAT_W = FLOAT_CODE_W + 1;

    typedef logic [PHASE_W-1:0] phase_cnt_t;
    typedef logic [FLOAT_W-1:0] float_cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DRAIN  = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic [SETUP_CODE_W-1:0] setup_code;
        phase_cnt_t              setup_hc;
        phase_cnt_t              pulse_hc;
        phase_cnt_t              hold_hc;
        float_cnt_t              float_hc;
        logic                    illegal;
    } bank_timing_t;

    // setup code s -> s + 0.5 bus cycles, code 0 -> none
    function automatic phase_cnt_t setup_halves(input logic [SETUP_CODE_W-1:0] code);
        int n;
        n = (code == '0) ? 0 : (2 * int'(code) + 1);
        return phase_cnt_t'(n);
    endfunction

    // strobe code c -> c + 1.5 bus cycles, plus one bus cycle with standard wait
    function automatic phase_cnt_t pulse_halves(input logic [PULSE_CODE_W-1:0] code,
                                                input logic std_wait);
        int n;
        n = 2 * int'(code) + 3 + (std_wait ? 2 : 0);
        return phase_cnt_t'(n);
    endfunction

    function automatic phase_cnt_t hold_halves(input logic [HOLD_CODE_W-1:0] code);
        return phase_cnt_t'(2 * int'(code));
    endfunction

    function automatic float_cnt_t float_halves(input logic [FLOAT_CODE_W-1:0] code);
        return float_cnt_t'(2 * int'(code));
    endfunction

    // setup left to insert once the pending float time of the previous bank overlaps it
    function automatic phase_cnt_t absorbed_setup(input logic [SETUP_CODE_W-1:0] code,
                                                  input float_cnt_t leftover);
        int twice_s;
        int left;
        twice_s = 2 * int'(code);
        left    = int'(leftover);
        if (code == '0 || left >= twice_s) begin
            return '0;
        end
        return phase_cnt_t'(twice_s + 1 - left);
    endfunction

endpackage

// File: rtl/smc_bank_timing.sv
module smc_bank_timing
    import smc_rd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_BANKS*SETUP_CODE_W-1:0] cfg_setup_i,
    input  logic [NUM_BANKS*PULSE_CODE_W-1:0] cfg_pulse_i,
    input  logic [NUM_BANKS*HOLD_CODE_W-1:0]  cfg_hold_i,
    input  logic [NUM_BANKS*FLOAT_CODE_W-1:0] cfg_float_i,
    input  logic [NUM_BANKS-1:0]              cfg_wait_i,
    input  logic [BANK_W-1:0]                 sel_i,
    output bank_timing_t                      tim_o
);

    bank_timing_t per_bank [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [SETUP_CODE_W-1:0] s_code;
        logic [PULSE_CODE_W-1:0] p_code;
        logic [HOLD_CODE_W-1:0]  h_code;
        logic [FLOAT_CODE_W-1:0] f_code;

        assign s_code = cfg_setup_i[b*SETUP_CODE_W +: SETUP_CODE_W];
        assign p_code = cfg_pulse_i[b*PULSE_CODE_W +: PULSE_CODE_W];
        assign h_code = cfg_hold_i[b*HOLD_CODE_W +: HOLD_CODE_W];
        assign f_code = cfg_float_i[b*FLOAT_CODE_W +: FLOAT_CODE_W];

        always_comb begin
            per_bank[b].setup_code = s_code;
            per_bank[b].setup_hc   = setup_halves(s_code);
            per_bank[b].pulse_hc   = pulse_halves(p_code, cfg_wait_i[b]);
            per_bank[b].hold_hc    = hold_halves(h_code);
            per_bank[b].float_hc   = float_halves(f_code);
            // setup without hold and without the standard wait is not a usable timing
            per_bank[b].illegal    = (s_code != '0) && (h_code == '0) && !cfg_wait_i[b];
        end
    end

    assign tim_o = per_bank[sel_i];

endmodule

// File: rtl/smc_float_tracker.sv
module smc_float_tracker
    import smc_rd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BANK_W-1:0] load_bank_i,
    input  float_cnt_t        load_val_i,
    input  logic [BANK_W-1:0] qa_bank_i,
    input  logic [BANK_W-1:0] qb_bank_i,
    output float_cnt_t        qa_cnt_o,
    output float_cnt_t        qb_cnt_o
);

    float_cnt_t cnt_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cnt
        logic load_here;
        assign load_here = load_i && (load_bank_i == BANK_W'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[b] <= '0;
            end else if (load_here) begin
                cnt_q[b] <= load_val_i;
            end else if (cnt_q[b] != '0) begin
                cnt_q[b] <= cnt_q[b] - float_cnt_t'(1);
            end
        end

        // R7/R9: float time falls by one per cycle until reloaded
        a_r9_float_countdown: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_here && cnt_q[b] != '0) |=> (cnt_q[b] == $past(cnt_q[b]) - float_cnt_t'(1)));
    end

    assign qa_cnt_o = cnt_q[qa_bank_i];
    assign qb_cnt_o = cnt_q[qb_bank_i];

endmodule

// File: rtl/smc_rd_fsm.sv
module smc_rd_fsm
    import smc_rd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [BANK_W-1:0]    req_bank_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  bank_timing_t         tim_i,
    input  float_cnt_t           own_float_i,
    input  float_cnt_t           prev_float_i,
    input  logic [DATA_W-1:0]    mem_data_i,
    output logic [BANK_W-1:0]    sel_o,
    output logic [BANK_W-1:0]    prev_bank_o,
    output logic                 fin_o,
    output float_cnt_t           fin_float_o,
    output logic                 ready_o,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [NUM_BANKS-1:0] cs_n_o,
    output logic                 rd_n_o
);

    seq_state_t  state_q, state_d;
    phase_cnt_t  cnt_q, cnt_d;
    phase_cnt_t  ins_setup;
    logic [BANK_W-1:0] cur_bank_q, prev_bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rdata_q;
    logic        done_q, err_q;
    logic        accept, refuse, capture, fin;

    // timing and float lookups follow the request while idle, the latched bank otherwise
    assign sel_o       = (state_q == ST_IDLE) ? req_bank_i : cur_bank_q;
    assign prev_bank_o = prev_bank_q;

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        accept    = 1'b0;
        refuse    = 1'b0;
        capture   = 1'b0;
        fin       = 1'b0;
        ins_setup = absorbed_setup(tim_i.setup_code, prev_float_i);
        unique case (state_q)
            ST_IDLE: begin
                if (req_i) begin
                    if (tim_i.illegal) begin
                        refuse = 1'b1;
                    end else begin
                        accept = 1'b1;
                        if (own_float_i != '0) begin
                            state_d = ST_DRAIN;
                        end else if (ins_setup != '0) begin
                            state_d = ST_SETUP;
                            cnt_d   = ins_setup;
                        end else begin
                            state_d = ST_STROBE;
                            cnt_d   = tim_i.pulse_hc;
                        end
                    end
                end
            end
            ST_DRAIN: begin
                if (own_float_i == '0) begin
                    if (tim_i.setup_hc != '0) begin
                        state_d = ST_SETUP;
                        cnt_d   = tim_i.setup_hc;
                    end else begin
                        state_d = ST_STROBE;
                        cnt_d   = tim_i.pulse_hc;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_q == phase_cnt_t'(1)) begin
                    state_d = ST_STROBE;
                    cnt_d   = tim_i.pulse_hc;
                end else begin
                    cnt_d = cnt_q - phase_cnt_t'(1);
                end
            end
            ST_STROBE: begin
                if (cnt_q == phase_cnt_t'(1)) begin
                    capture = 1'b1;
                    if (tim_i.hold_hc != '0) begin
                        state_d = ST_HOLD;
                        cnt_d   = tim_i.hold_hc;
                    end else begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                        fin     = 1'b1;
                    end
                end else begin
                    cnt_d = cnt_q - phase_cnt_t'(1);
                end
            end
            ST_HOLD: begin
                if (cnt_q == phase_cnt_t'(1)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                    fin     = 1'b1;
                end else begin
                    cnt_d = cnt_q - phase_cnt_t'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign fin_o       = fin;
    assign fin_float_o = tim_i.float_hc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs and access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_bank_q  <= '0;
            prev_bank_q <= '0;
            addr_q      <= '0;
            rdata_q     <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            done_q <= fin;
            err_q  <= refuse;
            if (accept) begin
                cur_bank_q  <= req_bank_i;
                prev_bank_q <= req_bank_i;
                addr_q      <= req_addr_i;
            end
            if (capture) begin
                rdata_q <= mem_data_i;
            end
        end
    end

    // bus-side decode
    always_comb begin
        cs_n_o  = '1;
        rd_n_o  = 1'b1;
        ready_o = (state_q == ST_IDLE);
        unique case (state_q)
            ST_SETUP, ST_HOLD: cs_n_o[cur_bank_q] = 1'b0;
            ST_STROBE: begin
                cs_n_o[cur_bank_q] = 1'b0;
                rd_n_o             = 1'b0;
            end
            default: ;
        endcase
    end

    assign addr_o  = addr_q;
    assign rdata_o = rdata_q;
    assign done_o  = done_q;
    assign err_o   = err_q;

    a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));
    a_r4_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !(&cs_n_o));
    a_r5_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_refused_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ((&cs_n_o) && ready_o));
    a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |=> $stable(addr_o));
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> ((&cs_n_o) && rd_n_o));

endmodule

// File: rtl/smc_read_seq.sv
module smc_read_seq
    import smc_rd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_BANKS*SETUP_CODE_W-1:0] cfg_setup_i,
    input  logic [NUM_BANKS*PULSE_CODE_W-1:0] cfg_pulse_i,
    input  logic [NUM_BANKS*HOLD_CODE_W-1:0]  cfg_hold_i,
    input  logic [NUM_BANKS*FLOAT_CODE_W-1:0] cfg_float_i,
    input  logic [NUM_BANKS-1:0]              cfg_wait_i,
    input  logic                              req_i,
    input  logic [BANK_W-1:0]                 req_bank_i,
    input  logic [ADDR_W-1:0]                 req_addr_i,
    output logic                              req_ready_o,
    output logic [DATA_W-1:0]                 rd_data_o,
    output logic                              rd_done_o,
    output logic                              cfg_err_o,
    output logic [ADDR_W-1:0]                 mem_addr_o,
    output logic [NUM_BANKS-1:0]              mem_cs_n_o,
    output logic                              mem_rd_n_o,
    input  logic [DATA_W-1:0]                 mem_data_i
);

    bank_timing_t      tim;
    logic [BANK_W-1:0] sel_bank, prev_bank;
    float_cnt_t        own_float, prev_float, fin_float;
    logic              fin;

    smc_bank_timing #(.NUM_BANKS(NUM_BANKS)) u_timing (
        .cfg_setup_i (cfg_setup_i),
        .cfg_pulse_i (cfg_pulse_i),
        .cfg_hold_i  (cfg_hold_i),
        .cfg_float_i (cfg_float_i),
        .cfg_wait_i  (cfg_wait_i),
        .sel_i       (sel_bank),
        .tim_o       (tim)
    );

    smc_float_tracker #(.NUM_BANKS(NUM_BANKS)) u_float (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (fin),
        .load_bank_i (sel_bank),
        .load_val_i  (fin_float),
        .qa_bank_i   (sel_bank),
        .qb_bank_i   (prev_bank),
        .qa_cnt_o    (own_float),
        .qb_cnt_o    (prev_float)
    );

    smc_rd_fsm #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .req_bank_i   (req_bank_i),
        .req_addr_i   (req_addr_i),
        .tim_i        (tim),
        .own_float_i  (own_float),
        .prev_float_i (prev_float),
        .mem_data_i   (mem_data_i),
        .sel_o        (sel_bank),
        .prev_bank_o  (prev_bank),
        .fin_o        (fin),
        .fin_float_o  (fin_float),
        .ready_o      (req_ready_o),
        .rdata_o      (rd_data_o),
        .done_o       (rd_done_o),
        .err_o        (cfg_err_o),
        .addr_o       (mem_addr_o),
        .cs_n_o       (mem_cs_n_o),
        .rd_n_o       (mem_rd_n_o)
    );

endmodule

// File: tb/smc_read_seq_test.sv
module smc_read_seq_test;

    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NB*3-1:0] cfg_setup;
    logic [NB*7-1:0] cfg_pulse;
    logic [NB*3-1:0] cfg_hold;
    logic [NB*4-1:0] cfg_float;
    logic [NB-1:0]   cfg_wait;
    logic        req = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_addr = '0;
    logic        ready, done, err, rd_n;
    logic [15:0] rdata, maddr;
    logic [NB-1:0] cs_n;
    logic [15:0] mdata = '0;

    int bset [NB];
    int bpul [NB];
    int bhld [NB];
    int bflt [NB];
    int bwt  [NB];

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            cfg_setup[b*3 +: 3] = 3'(bset[b]);
            cfg_pulse[b*7 +: 7] = 7'(bpul[b]);
            cfg_hold[b*3 +: 3]  = 3'(bhld[b]);
            cfg_float[b*4 +: 4] = 4'(bflt[b]);
            cfg_wait[b]         = (bwt[b] != 0);
        end
    end

    smc_read_seq #(.NUM_BANKS(NB), .ADDR_W(16), .DATA_W(16)) uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_setup_i (cfg_setup), .cfg_pulse_i (cfg_pulse), .cfg_hold_i (cfg_hold),
        .cfg_float_i (cfg_float), .cfg_wait_i (cfg_wait),
        .req_i (req), .req_bank_i (req_bank), .req_addr_i (req_addr),
        .req_ready_o (ready), .rd_data_o (rdata), .rd_done_o (done), .cfg_err_o (err),
        .mem_addr_o (maddr), .mem_cs_n_o (cs_n), .mem_rd_n_o (rd_n), .mem_data_i (mdata)
    );

    task automatic check(input bit ok, input string req_tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req_tag, what, act, exp);
        end
    endtask

    // expected setup half-cycles from R2/R7/R8, leftover L in half-cycles
    function automatic int exp_setup(input int s, input int left);
        if (s == 0 || left >= 2 * s) return 0;
        return 2 * s + 1 - left;
    endfunction

    // drive one request at the current negedge and measure the access at the ports
    task automatic run_read(input int bank, input logic [15:0] addr, input int e_gap,
                            input int e_setup, input int e_pulse, input int e_hold,
                            input string tag, input int inject_at);
        int gap = 0, su = 0, pu = 0, ho = 0, n = 0;
        int bad_cs = 0, bad_addr = 0;
        bit seen = 0;
        logic [15:0] last_d = '0;
        logic [NB-1:0] exp_cs;
        exp_cs = ~(NB'(1) << bank);
        req = 1'b1; req_bank = 2'(bank); req_addr = addr;
        @(negedge clk);
        req = 1'b0;
        forever begin
            if (&cs_n) begin
                if (seen) break;
                gap++;
            end else begin
                seen = 1;
                if (cs_n != exp_cs) bad_cs++;
                if (maddr != addr) bad_addr++;
                if (!rd_n) begin
                    pu++;
                    mdata = 16'(16'hA500 + n);
                    last_d = mdata;
                end else if (pu == 0) su++;
                else ho++;
            end
            if (inject_at >= 0) begin
                req = (n == inject_at);
                req_bank = (n == inject_at) ? 2'd2 : 2'(bank);
                req_addr = (n == inject_at) ? 16'h7777 : addr;
            end
            n++;
            if (n > 1000) break;
            @(negedge clk);
        end
        req = 1'b0;
        check(gap == e_gap, tag, "idle gap before select", gap, e_gap);
        check(su == e_setup, tag, "setup cycles", su, e_setup);
        check(pu == e_pulse, "R3", "strobe cycles", pu, e_pulse);
        check(ho == e_hold, "R4", "hold cycles", ho, e_hold);
        check(bad_cs == 0, "R6", "cycles with wrong select", bad_cs, 0);
        check(bad_addr == 0, "R6", "cycles with wrong address", bad_addr, 0);
        check(done == 1'b1, "R5", "done in release cycle", int'(done), 1);
        check(rdata == last_d, "R5", "captured data", int'(rdata), int'(last_d));
    endtask

    task automatic t_reset;
        check(cs_n == '1, "R1", "selects after reset", int'(cs_n), 15);
        check(rd_n == 1'b1, "R1", "strobe after reset", int'(rd_n), 1);
        check(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
        check(done == 1'b0 && err == 1'b0, "R1", "done/err after reset", int'({done, err}), 0);
    endtask

    task automatic t_basic;
        // R2: s=2 -> 5 setup, c=3 -> 9 strobe, h=2 -> 4 hold
        run_read(0, 16'h1234, 0, exp_setup(2, 0), 9, 4, "R2", -1);
        @(negedge clk);
        check(done == 1'b0, "R5", "done drops after one cycle", int'(done), 0);
        check(ready && cs_n == '1 && rd_n, "R1", "bus released when idle", int'(cs_n), 15);
    endtask

    task automatic t_std_wait;
        // R3: c=0 with standard wait -> 5 strobe, s=1 -> 3 setup, no hold
        repeat (3) @(negedge clk);
        run_read(3, 16'h0BEE, 0, exp_setup(1, 0), 5, 0, "R2", -1);
    endtask

    task automatic t_absorb;
        // R7: bank0 float 3 leaves 6, bank1 s=2 needs 4 -> no setup, no gap
        repeat (3) @(negedge clk);
        run_read(0, 16'h2000, 0, 5, 9, 4, "R2", -1);
        run_read(1, 16'h3001, 0, exp_setup(2, 6), 5, 2, "R7", -1);
        // R8: bank1 float 1 leaves 2, bank2 s=5 -> 11-2 = 9 setup
        run_read(2, 16'h4002, 0, exp_setup(5, 2), 7, 2, "R8", -1);
        // R9: same bank, its float 2 leaves 4 -> 4 idle cycles then full 11 setup
        run_read(2, 16'h4003, 4, 11, 7, 2, "R9", -1);
    endtask

    task automatic t_busy;
        // R11: request to bank 2 injected during a long bank0 strobe
        bpul[0] = 20;
        bflt[0] = 0;
        repeat (12) @(negedge clk);
        run_read(0, 16'h5555, 0, 5, 43, 4, "R11", 10);
        repeat (4) begin
            @(negedge clk);
            check(cs_n == '1 && ready, "R11", "no access after ignored request",
                  int'(cs_n), 15);
        end
    endtask

    task automatic t_illegal;
        // R10: setup 3, hold 0, no standard wait
        bset[3] = 3; bhld[3] = 0; bwt[3] = 0;
        @(negedge clk);
        req = 1'b1; req_bank = 2'd3; req_addr = 16'h0666;
        @(negedge clk);
        req = 1'b0;
        check(err == 1'b1, "R10", "error pulse", int'(err), 1);
        check(cs_n == '1 && ready, "R10", "no select on refusal", int'(cs_n), 15);
        @(negedge clk);
        check(err == 1'b0, "R10", "error one cycle", int'(err), 0);
        check(cs_n == '1 && rd_n && !done, "R10", "still idle", int'(cs_n), 15);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 20000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bset = '{2, 2, 5, 1};
        bpul = '{3, 1, 2, 0};
        bhld = '{2, 1, 1, 0};
        bflt = '{0, 1, 2, 0};
        bwt  = '{0, 0, 0, 1};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_std_wait();
        bflt[0] = 3;
        t_absorb();
        t_busy();
        t_illegal();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule